// File: doc/BRIEF.md
# Serial Multiplier with Held Multiplicand

This block forms the unsigned product of two `WIDTH`-bit operands while handling only one multiplier bit at a time. A start strobe latches the whole multiplicand from a parallel bus into a row of storage cells. These cells keep their contents for the whole operation, so reading them does not consume them. The multiplier then arrives on a one-bit input, least significant bit first, one bit per clock.

Each column of the datapath ANDs its held multiplicand bit with the current multiplier bit to make a partial-product bit. It adds that bit into a one-bit running sum with a full adder that keeps its carry locally from one cycle to the next. On every clock, each column passes its sum bit one place toward the least significant end. This is the opposite direction to the growth of the multiplier bit index. The column at the low end therefore delivers one product bit per clock.

Once the last multiplier bit has been taken, zeros are fed into the columns in its place so that the stored carries drain out. The full `2*WIDTH`-bit product leaves serially over `2*WIDTH` cycles, qualified by a valid strobe. A busy flag covers the operation, and a start strobe that arrives while the unit is busy is dropped.

Top module: `serial_mul_nd`

## Requirements
- R1: After reset, `busy`, `prod_valid` and `prod_bit` are all 0.
- R2: A start is accepted on a clock edge where `start` is 1 and `busy` is 0. On that edge `b_load` is captured as the multiplicand, and `busy` reads 1 in the cycle that follows.
- R3: Multiplier bit k (k = 0 is the least significant) is sampled from `a_in` on the (k+1)-th edge after acceptance, for k = 0 to WIDTH-1. On the remaining WIDTH edges of the operation, `a_in` is ignored and zero is used in its place.
- R4: Product bit k (k = 0 is the least significant) is on `prod_bit` in the cycle after the (k+1)-th edge following acceptance. `prod_valid` is 1 for exactly those 2*WIDTH consecutive cycles and 0 in the cycle after the last of them.
- R5: The 2*WIDTH serial bits equal A*B for any operands, including zero and all-ones operands.
- R6: `busy` stays 1 for exactly 2*WIDTH cycles after acceptance. A new start is accepted in the first cycle in which `busy` is 0, so operations can run back to back.
- R7: A `start` pulse while `busy` is 1 is ignored. It does not reload the multiplicand and does not restart or lengthen the operation.
- R8: Changes on `b_load` after acceptance have no effect on the running product.
- R9: With a stored multiplicand of zero, every valid product bit is 0, whatever multiplier bits arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start strobe; takes effect only when the unit is idle |
| b_load | input | WIDTH | Parallel multiplicand, captured on acceptance |
| a_in | input | 1 | Serial multiplier, least significant bit first |
| busy | output | 1 | High while an operation is running |
| prod_bit | output | 1 | Serial product bit, least significant bit first |
| prod_valid | output | 1 | Qualifies `prod_bit` |

## Verification
The operand pairs are chosen so that each one exposes a different kind of fault.
- Zero and all-ones operands test the longest carry chains and the last product bit, which depends entirely on carries draining out during the zero-fill.
- Single-bit and alternating patterns expose a swapped column, a column that is off by one, or a misordered output bit.
- Driving `a_in` high during the drain phase distinguishes zero-fill from sampling the pin.
- A start pulse or a changed `b_load` in the middle of a run distinguishes dropped from honoured requests and held from live multiplicand storage.
- A back-to-back series of pseudo-random pairs catches carries left over from the previous operation.

// File: rtl/smul_pkg.sv
// Shared types and helpers for the serial multiplier.
// Assumes single-bit operands for the adder helper.
package smul_pkg;

    typedef struct packed {
        logic carry;
        logic sum;
    } fa_t;

    // One-bit full addition of three inputs.
    function automatic fa_t full_add(input logic x, input logic y, input logic z);
        fa_t r;
        r.sum   = x ^ y ^ z;
        r.carry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

endpackage

// File: rtl/smul_seq.sv
// Operation sequencer: accepts a start when idle, counts the 2*WIDTH steps,
// substitutes zero for the multiplier input once WIDTH bits have been taken,
// and produces the busy and valid strobes.
// Assumes WIDTH >= 1.
module smul_seq #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic a_in,
    output logic accept,
    output logic step,
    output logic a_gate,
    output logic busy,
    output logic prod_valid
);
    localparam int TOTAL = 2 * WIDTH;
    localparam int CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] cnt;
    logic          last;

    // Decode acceptance, the step enable, the final step and the gated multiplier bit.
    always_comb begin
        accept = start & ~busy;
        step   = busy;
        last   = busy && (cnt == CW'(TOTAL - 1));
        a_gate = busy && (cnt < CW'(WIDTH)) && a_in;
    end

    // Step counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (last) busy <= 1'b0;
        end
    end

    // A product bit is produced on every step edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prod_valid <= 1'b0;
        else        prod_valid <= busy;
    end

endmodule

// File: rtl/smul_column.sv
// One column of the multiplier: a held multiplicand bit that is not consumed
// by reading, an AND gate forming the partial-product bit, and a full adder
// whose sum and carry are kept in registers. The sum from the column above
// arrives on sum_in and this column's sum leaves toward the column below.
// Assumes load and step are never high together.
module smul_column (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic b_bit,
    input  logic step,
    input  logic a_bit,
    input  logic sum_in,
    output logic sum_q
);
    import smul_pkg::*;

    logic b_q;
    logic carry_q;
    fa_t  nxt;

    // Partial-product bit added to the incoming sum and the local carry.
    always_comb nxt = full_add(b_q & a_bit, sum_in, carry_q);

    // Multiplicand bit storage, written only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)    b_q <= 1'b0;
        else if (load) b_q <= b_bit;
    end

    // Sum and carry storage: cleared on acceptance, advanced on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            sum_q   <= 1'b0;
            carry_q <= 1'b0;
        end else if (step) begin
            sum_q   <= nxt.sum;
            carry_q <= nxt.carry;
        end
    end

endmodule

// File: rtl/serial_mul_nd.sv
// Top level of the serial multiplier. It instantiates the sequencer and a row
// of WIDTH columns; sums flow from the top column toward column 0, whose sum
// register is the serial product output.
// Assumes unsigned operands and one operation in flight at a time.
module serial_mul_nd #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] b_load,
    input  logic             a_in,
    output logic             busy,
    output logic             prod_bit,
    output logic             prod_valid
);
    logic             accept;
    logic             step;
    logic             a_gate;
    logic [WIDTH:0]   sum_chain;

    assign sum_chain[WIDTH] = 1'b0;
    assign prod_bit         = sum_chain[0];

    smul_seq #(.WIDTH(WIDTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .a_in       (a_in),
        .accept     (accept),
        .step       (step),
        .a_gate     (a_gate),
        .busy       (busy),
        .prod_valid (prod_valid)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_col
        smul_column u_col (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (accept),
            .b_bit  (b_load[i]),
            .step   (step),
            .a_bit  (a_gate),
            .sum_in (sum_chain[i+1]),
            .sum_q  (sum_chain[i])
        );
    end

endmodule

// File: rtl/smul_checker.sv
// Protocol checker for serial_mul_nd: busy window length, valid timing and
// the zero-multiplicand property. It keeps its own copy of the accepted
// multiplicand and its own busy-cycle counter.
module smul_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [WIDTH-1:0] b_load,
    input logic             busy,
    input logic             prod_bit,
    input logic             prod_valid
);
    localparam int TOTAL = 2 * WIDTH;
    localparam int BW    = $clog2(TOTAL + 1) + 1;

    logic [BW-1:0]    bcnt;
    logic [WIDTH-1:0] bcap;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    // Keep the multiplicand seen on each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                bcap <= '0;
        else if (start && !busy)   bcap <= b_load;
    end

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                                   // R2
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bcnt < BW'(TOTAL - 1)) |=> busy);                    // R7
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == BW'(TOTAL)));                        // R6
    AST_VALID_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> $rose(prod_valid));                           // R4
    AST_VALID_END: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && !busy) |=> !prod_valid);                       // R4
    AST_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && bcap == '0) |-> !prod_bit);                    // R9

endmodule

bind serial_mul_nd smul_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .b_load     (b_load),
    .busy       (busy),
    .prod_bit   (prod_bit),
    .prod_valid (prod_valid)
);

// File: tb/serial_mul_nd_tb.sv
// Directed bench for serial_mul_nd: one task per scenario, each checking its results.
module serial_mul_nd_tb;
    localparam int W     = 8;
    localparam int TOTAL = 2 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] b_load = '0;
    logic         a_in = 1'b0;
    logic         busy;
    logic         prod_bit;
    logic         prod_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    serial_mul_nd #(.WIDTH(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .b_load     (b_load),
        .a_in       (a_in),
        .busy       (busy),
        .prod_bit   (prod_bit),
        .prod_valid (prod_valid)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reset values; called at a negedge with reset released.
    task automatic t_reset();
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(prod_valid == 1'b0, "R1", "valid after reset", prod_valid, 0);
        check(prod_bit == 1'b0, "R1", "prod_bit after reset", prod_bit, 0);
    endtask

    // One operation. mode 0 plain, 1 a_in high in drain (R3),
    // 2 start pulse with other B mid-run (R7), 3 b_load changed mid-run (R8).
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input int mode, input string req);
        logic [TOTAL-1:0] p = '0;
        logic [TOTAL-1:0] exp_p;
        bit vbad = 1'b0;
        bit bbad = 1'b0;
        exp_p = TOTAL'(a) * TOTAL'(b);
        start  = 1'b1;
        b_load = b;
        a_in   = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R2", "busy after accept", busy, 1);
        for (int k = 0; k < TOTAL; k++) begin
            a_in   = (k < W) ? a[k] : (mode == 1);
            start  = (mode == 2 && (k == 2 || k == W)) ? 1'b1 : 1'b0;
            b_load = ((mode == 2 || mode == 3) && k >= 1) ? ~b : b;
            @(negedge clk);
            p[k] = prod_bit;
            if (!prod_valid) vbad = 1'b1;
            if (k < TOTAL - 1 && !busy) bbad = 1'b1;
        end
        start = 1'b0;
        a_in  = 1'b0;
        check(p == exp_p, req, "product", p, exp_p);
        check(!vbad, "R4", "valid held over 2W cycles", vbad, 0);
        check(!bbad && !busy, "R6", "busy window 2W cycles", busy, 0);
    endtask

    // Idle one cycle and check that valid has dropped.
    task automatic t_valid_drop();
        @(negedge clk);
        check(prod_valid == 1'b0, "R4", "valid low after last bit", prod_valid, 0);
        check(busy == 1'b0, "R6", "idle stays idle", busy, 0);
    endtask

    // Back-to-back series of pseudo-random operands.
    task automatic t_random(input int count);
        logic [31:0] s = 32'h1234_5678;
        for (int i = 0; i < count; i++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 17);
            s = s ^ (s << 5);
            run_op(s[W-1:0], s[2*W-1:W], 0, "R5");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_op('0, '0, 0, "R5");
        run_op('1, '1, 0, "R5");
        run_op(8'd1, '1, 0, "R5");
        run_op('1, 8'd1, 0, "R5");
        run_op(8'hAA, 8'h55, 0, "R5");
        run_op(8'h80, 8'h80, 0, "R5");
        run_op(8'hC3, 8'h00, 0, "R9");
        run_op('1, 8'h00, 1, "R9");
        run_op(8'h00, 8'h9D, 0, "R5");
        run_op(8'h0F, 8'hF0, 1, "R3");
        run_op(8'h01, 8'hFF, 1, "R3");
        run_op(8'h6B, 8'h2C, 2, "R7");
        run_op(8'hFF, 8'h01, 3, "R8");
        t_valid_drop();
        run_op(8'h37, 8'hE9, 0, "R6");
        t_random(40);
        t_valid_drop();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule